// File: doc/BRIEF.md
# Receive Descriptor Ring Position Tracker

This block follows a network controller's place in a circular ring of receive descriptors held in memory. It keeps a ring counter that starts at the ring length and counts down toward one, then wraps. From this counter it forms the byte address of the current descriptor and of the two that follow it. The stride between descriptors is 8 or 16 bytes, chosen by a style select.

When a frame arrives, the surrounding logic presents the frame length together with the ownership bit and byte-count field of the three upcoming descriptors. In one cycle the block decides how many owned descriptors the frame fills, at most three, and whether the whole frame fit. It then reports the per-descriptor status update, advances the ring counter by the number of descriptors used, and raises the receive-done flag. If the current descriptor is not owned, the block records a missed frame instead. Moving the frame data and the descriptor memory accesses belong to neighbouring logic.

Top module: `rdt_ring_tracker`

## Requirements
- R1: After reset, ring_idx is 0, upd_valid is 0, intr_stat is 0 and miss_cnt is 0. Until the first init pulse, frame requests change nothing.
- R2: An init pulse loads ring_idx with ring_len and clears intr_stat and miss_cnt. A frame request in the same cycle as init is dropped.
- R3: desc_addr slot k (bits k*ADDR_W upward; slot 0 is current, slot 1 is next, slot 2 is the one after) equals ring_base + (ring_len − c_k) × stride. The stride is 16 when wide_desc is 1 and 8 when it is 0. c_0 is ring_idx.
- R4: c_(k+1) is ring_len when c_k ≤ 1, and c_k − 1 otherwise.
- R5: The capacity of descriptor k is 4096 − desc_bcnt slot k, so a byte-count of 0 gives 4096 bytes.
- R6: Slot 0 is used when desc_own[0] is 1. Slot k > 0 is used only when slot k−1 was used, desc_own[k] is 1 and bytes remain. upd_used bit k marks a descriptor whose ownership is returned. Bit 0 is the start-of-frame descriptor.
- R7: If the frame fits in the used descriptors, upd_end is 1, upd_err is 0 and upd_mlen equals frm_len. Otherwise upd_err is 1 (overflow plus buffer error), upd_end is 0 and upd_mlen is 0.
- R8: After a stored frame, ring_idx has been stepped with the R4 rule once per used descriptor.
- R9: A frame request whose current descriptor is not owned sets intr_stat bit 12 and increments miss_cnt. It leaves ring_idx unchanged and produces no update.
- R10: Every stored frame sets intr_stat bit 10, whether it ends normally or with an error. The bit holds until the next init.
- R11: A frame request with frm_len 0 has no effect.
- R12: All results appear on the outputs one clock after the request edge. upd_valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Byte address of the ring start |
| ring_len | input | CNT_W | Number of descriptors in the ring |
| wide_desc | input | 1 | 1 selects a 16-byte stride, 0 selects an 8-byte stride |
| init | input | 1 | Load the ring counter and clear the flags |
| frm_valid | input | 1 | Frame request strobe |
| frm_len | input | LEN_W | Frame length in bytes |
| desc_own | input | MAX_SPAN | Ownership bit of each upcoming descriptor |
| desc_bcnt | input | MAX_SPAN*BCNT_W | Byte-count field of each upcoming descriptor |
| ring_idx | output | CNT_W | Ring counter |
| desc_addr | output | MAX_SPAN*ADDR_W | Addresses of the current, next and after-next descriptors |
| upd_valid | output | 1 | Status update pulse |
| upd_used | output | MAX_SPAN | Descriptors filled (ownership cleared) |
| upd_end | output | 1 | End flag on the last descriptor; the frame fit |
| upd_err | output | 1 | Overflow and buffer error |
| upd_mlen | output | LEN_W | Total message length when upd_end is 1 |
| intr_stat | output | 16 | Bit 12 is missed frame, bit 10 is receive done; other bits are 0 |
| miss_cnt | output | MISS_W | Count of missed frames, wrapping |

## Verification
The assertions assume that ring_len is nonzero and stays constant from an init pulse until the frames that use it, and that frm_len never exceeds what LEN_W holds. The stimulus honours this: ring_len and wide_desc change only in the same cycle as an init pulse, ring lengths are drawn from 1 to 20, and frame lengths are drawn below 12300. Ownership bits and byte counts are drawn so that single-descriptor fits, multi-descriptor spans, overflows and misses all occur. Directed cases cover exact 4096-byte boundaries and a one-entry ring.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
   localparam int STAT_W     = 16;
   localparam int MISS_POS   = 12;
   localparam int RXDONE_POS = 10;
   localparam int NARROW_SH  = 3;
   localparam int WIDE_SH    = 4;
endpackage

// File: rtl/rdt_slot_addr.sv
module rdt_slot_addr #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  ring_len,
   input  logic              wide,
   input  logic [CNT_W-1:0]  cnt,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  cnt_after
);
   import rdt_pkg::*;
   logic [ADDR_W-1:0] span;

   always_comb begin
      span = ADDR_W'(ring_len) - ADDR_W'(cnt);
      addr = base + (wide ? (span << WIDE_SH) : (span << NARROW_SH));
      cnt_after = (cnt <= CNT_W'(1)) ? ring_len : cnt - CNT_W'(1);
   end
endmodule

// File: rtl/rdt_frame_fill.sv
module rdt_frame_fill #(
   parameter int MAX_SPAN = 3,
   parameter int BCNT_W   = 12,
   parameter int LEN_W    = 14,
   localparam int NU_W    = $clog2(MAX_SPAN + 1)
) (
   input  logic [LEN_W-1:0]           frm_len,
   input  logic [MAX_SPAN-1:0]        own,
   input  logic [MAX_SPAN*BCNT_W-1:0] bcnt,
   output logic [MAX_SPAN-1:0]        used,
   output logic [NU_W-1:0]            n_used,
   output logic                       fit
);
   logic [LEN_W-1:0] rem [0:MAX_SPAN];

   assign rem[0] = frm_len;

   for (genvar k = 0; k < MAX_SPAN; k++) begin : g_slot
      logic [LEN_W-1:0] cap, chunk;
      assign cap   = LEN_W'(1 << BCNT_W) - LEN_W'(bcnt[k*BCNT_W +: BCNT_W]);
      assign chunk = (cap < rem[k]) ? cap : rem[k];
      if (k == 0) begin : g_first
         assign used[k] = own[k] && (rem[k] != '0);
      end else begin : g_chain
         assign used[k] = used[k-1] && own[k] && (rem[k] != '0);
      end
      assign rem[k+1] = used[k] ? rem[k] - chunk : rem[k];
   end

   always_comb begin
      n_used = '0;
      for (int i = 0; i < MAX_SPAN; i++) n_used = n_used + NU_W'(used[i]);
   end

   assign fit = used[0] && (rem[MAX_SPAN] == '0);
endmodule

// File: rtl/rdt_ring_tracker.sv
module rdt_ring_tracker #(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 16,
   parameter int BCNT_W   = 12,
   parameter int LEN_W    = 14,
   parameter int MISS_W   = 16,
   parameter int MAX_SPAN = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          ring_base,
   input  logic [CNT_W-1:0]           ring_len,
   input  logic                       wide_desc,
   input  logic                       init,
   input  logic                       frm_valid,
   input  logic [LEN_W-1:0]           frm_len,
   input  logic [MAX_SPAN-1:0]        desc_own,
   input  logic [MAX_SPAN*BCNT_W-1:0] desc_bcnt,
   output logic [CNT_W-1:0]           ring_idx,
   output logic [MAX_SPAN*ADDR_W-1:0] desc_addr,
   output logic                       upd_valid,
   output logic [MAX_SPAN-1:0]        upd_used,
   output logic                       upd_end,
   output logic                       upd_err,
   output logic [LEN_W-1:0]           upd_mlen,
   output logic [15:0]                intr_stat,
   output logic [MISS_W-1:0]          miss_cnt
);
   import rdt_pkg::*;
   localparam int NU_W = $clog2(MAX_SPAN + 1);

   if (MAX_SPAN < 1 || MAX_SPAN > 3) begin : g_bad_span
      $error("MAX_SPAN must be 1 to 3");
   end
   if (LEN_W < BCNT_W + 1) begin : g_bad_len
      $error("LEN_W too narrow for a full buffer");
   end
   if (CNT_W + WIDE_SH > ADDR_W) begin : g_bad_cnt
      $error("CNT_W too wide for ADDR_W");
   end

   logic              armed_q, miss_q, rxdone_q;
   logic [CNT_W-1:0]  cnt_chain [0:MAX_SPAN];
   logic [MAX_SPAN-1:0] used;
   logic [NU_W-1:0]   n_used;
   logic              fit, take_frame;

   assign cnt_chain[0] = ring_idx;

   for (genvar k = 0; k < MAX_SPAN; k++) begin : g_addr
      rdt_slot_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_slot (
         .base      (ring_base),
         .ring_len  (ring_len),
         .wide      (wide_desc),
         .cnt       (cnt_chain[k]),
         .addr      (desc_addr[k*ADDR_W +: ADDR_W]),
         .cnt_after (cnt_chain[k+1])
      );
   end

   rdt_frame_fill #(.MAX_SPAN(MAX_SPAN), .BCNT_W(BCNT_W), .LEN_W(LEN_W)) i_fill (
      .frm_len (frm_len),
      .own     (desc_own),
      .bcnt    (desc_bcnt),
      .used    (used),
      .n_used  (n_used),
      .fit     (fit)
   );

   assign take_frame = frm_valid && armed_q && !init && (frm_len != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         ring_idx  <= '0;
         miss_q    <= 1'b0;
         rxdone_q  <= 1'b0;
         miss_cnt  <= '0;
         upd_valid <= 1'b0;
         upd_used  <= '0;
         upd_end   <= 1'b0;
         upd_err   <= 1'b0;
         upd_mlen  <= '0;
      end else begin
         upd_valid <= 1'b0;
         upd_used  <= '0;
         upd_end   <= 1'b0;
         upd_err   <= 1'b0;
         upd_mlen  <= '0;
         if (init) begin
            armed_q  <= 1'b1;
            ring_idx <= ring_len;
            miss_q   <= 1'b0;
            rxdone_q <= 1'b0;
            miss_cnt <= '0;
         end else if (take_frame) begin
            if (used[0]) begin
               ring_idx  <= cnt_chain[n_used];
               upd_valid <= 1'b1;
               upd_used  <= used;
               upd_end   <= fit;
               upd_err   <= !fit;
               upd_mlen  <= fit ? frm_len : '0;
               rxdone_q  <= 1'b1;
            end else begin
               miss_q   <= 1'b1;
               miss_cnt <= miss_cnt + MISS_W'(1);
            end
         end
      end
   end

   always_comb begin
      intr_stat = '0;
      intr_stat[MISS_POS]   = miss_q;
      intr_stat[RXDONE_POS] = rxdone_q;
   end
endmodule

// File: rtl/rdt_ring_tracker_chk.sv
module rdt_ring_tracker_chk #(
   parameter int CNT_W    = 16,
   parameter int LEN_W    = 14,
   parameter int MISS_W   = 16,
   parameter int MAX_SPAN = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                init,
   input logic [CNT_W-1:0]    ring_len,
   input logic                frm_valid,
   input logic [LEN_W-1:0]    frm_len,
   input logic [MAX_SPAN-1:0] desc_own,
   input logic                armed_q,
   input logic [CNT_W-1:0]    ring_idx,
   input logic                upd_valid,
   input logic [MAX_SPAN-1:0] upd_used,
   input logic                upd_end,
   input logic                upd_err,
   input logic [LEN_W-1:0]    upd_mlen,
   input logic [15:0]         intr_stat,
   input logic [MISS_W-1:0]   miss_cnt
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   a_r2_init_load: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(init) |-> ring_idx == $past(ring_len) && miss_cnt == '0);

   a_r6_contiguous_use: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> upd_used[0] && $countones({1'b0, upd_used} + 1'b1) == 1);

   a_r7_end_or_error: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (upd_end ^ upd_err));

   a_r7_msg_length: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && upd_valid && upd_end |-> upd_mlen == $past(frm_len));

   a_r9_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(frm_valid && armed_q && !init && frm_len != '0 && !desc_own[0])
      |-> miss_cnt == $past(miss_cnt) + MISS_W'(1) && intr_stat[12] && !upd_valid
          && ring_idx == $past(ring_idx));

   a_r11_no_update_idle: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(frm_len == '0 || !armed_q || !frm_valid || init) |-> !upd_valid);

   a_r10_done_with_update: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> intr_stat[10]);
endmodule

bind rdt_ring_tracker rdt_ring_tracker_chk #(
   .CNT_W(CNT_W), .LEN_W(LEN_W), .MISS_W(MISS_W), .MAX_SPAN(MAX_SPAN)
) i_chk (
   .clk(clk), .rst_n(rst_n), .init(init), .ring_len(ring_len),
   .frm_valid(frm_valid), .frm_len(frm_len), .desc_own(desc_own),
   .armed_q(armed_q), .ring_idx(ring_idx), .upd_valid(upd_valid),
   .upd_used(upd_used), .upd_end(upd_end), .upd_err(upd_err),
   .upd_mlen(upd_mlen), .intr_stat(intr_stat), .miss_cnt(miss_cnt)
);

// File: tb/test_rdt_ring_tracker.sv
`timescale 1ns/1ps
module test_rdt_ring_tracker;
   localparam int ADDR_W = 32, CNT_W = 16, BCNT_W = 12, LEN_W = 14, MISS_W = 16, SP = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [ADDR_W-1:0] ring_base = '0;
   logic [CNT_W-1:0]  ring_len = '0;
   logic wide_desc = 1'b0, init = 1'b0, frm_valid = 1'b0;
   logic [LEN_W-1:0] frm_len = '0;
   logic [SP-1:0] desc_own = '0;
   logic [SP*BCNT_W-1:0] desc_bcnt = '0;
   logic [CNT_W-1:0] ring_idx;
   logic [SP*ADDR_W-1:0] desc_addr;
   logic upd_valid, upd_end, upd_err;
   logic [SP-1:0] upd_used;
   logic [LEN_W-1:0] upd_mlen;
   logic [15:0] intr_stat;
   logic [MISS_W-1:0] miss_cnt;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic m_armed = 0, m_miss = 0, m_rint = 0;
   logic [CNT_W-1:0] m_idx = 0;
   logic [MISS_W-1:0] m_mcnt = 0;

   always #2.5 clk = ~clk;

   rdt_ring_tracker i_rdt_ring_tracker (.*);

   function automatic logic [CNT_W-1:0] wrapc(logic [CNT_W-1:0] c, logic [CNT_W-1:0] l);
      return (c <= 1) ? l : c - 1;
   endfunction

   task automatic chk(string what, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", what, tag, act, exp);
      end
   endtask

   task automatic apply(input logic ini, input logic fv, input logic [LEN_W-1:0] len,
                        input logic [SP-1:0] own, input logic [SP*BCNT_W-1:0] bc, input string tag);
      logic [SP-1:0] e_used;
      logic e_valid, e_end, e_err;
      logic [LEN_W-1:0] e_mlen;
      logic [CNT_W-1:0] c;
      int rem, cap;
      init = ini; frm_valid = fv; frm_len = len; desc_own = own; desc_bcnt = bc;
      @(posedge clk);
      @(negedge clk);
      e_used = '0; e_valid = 0; e_end = 0; e_err = 0; e_mlen = '0;
      if (ini) begin
         m_armed = 1; m_idx = ring_len; m_miss = 0; m_rint = 0; m_mcnt = 0;
      end else if (fv && m_armed && len != 0) begin
         if (!own[0]) begin
            m_miss = 1; m_mcnt = m_mcnt + 1;
         end else begin
            rem = int'(len);
            for (int k = 0; k < SP; k++) begin
               if ((k == 0 || e_used[k>0 ? k-1 : 0]) && own[k] && rem > 0) begin
                  cap = 4096 - int'(bc[k*BCNT_W +: BCNT_W]);
                  rem = rem - ((cap < rem) ? cap : rem);
                  e_used[k] = 1'b1;
                  m_idx = wrapc(m_idx, ring_len);
               end
            end
            e_valid = 1; e_end = (rem == 0); e_err = (rem != 0);
            e_mlen = (rem == 0) ? len : '0;
            m_rint = 1;
         end
      end
      chk("R8/R2 ring_idx", tag, ring_idx, m_idx);
      chk("R12 upd_valid", tag, upd_valid, e_valid);
      chk("R6 upd_used", tag, upd_used, e_used);
      chk("R7 upd_end", tag, upd_end, e_end);
      chk("R7 upd_err", tag, upd_err, e_err);
      chk("R7 upd_mlen", tag, upd_mlen, e_mlen);
      chk("R9/R10 intr_stat", tag, intr_stat, {3'b0, m_miss, 1'b0, m_rint, 10'b0});
      chk("R9 miss_cnt", tag, miss_cnt, m_mcnt);
      c = m_idx;
      for (int k = 0; k < SP; k++) begin
         chk(k == 0 ? "R3 cur addr" : "R4 follow addr", tag, desc_addr[k*ADDR_W +: ADDR_W],
             ring_base + ((ADDR_W'(ring_len) - ADDR_W'(c)) << (wide_desc ? 4 : 3)));
         c = wrapc(c, ring_len);
      end
   endtask

   task automatic reinit(input logic [ADDR_W-1:0] b, input logic [CNT_W-1:0] l, input logic w, input string tag);
      ring_base = b; ring_len = l; wide_desc = w;
      apply(1, 0, 0, 0, 0, tag);
   endtask

   function automatic logic [BCNT_W-1:0] rnd_bcnt();
      case ($urandom % 4)
         0: return '0;
         1: return BCNT_W'(4096 - 1 - ($urandom % 64));
         2: return BCNT_W'(2048 + $urandom % 2048);
         default: return BCNT_W'($urandom);
      endcase
   endfunction

   initial begin
      void'($urandom(32'h5eed_2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset ring_idx", "reset", ring_idx, 0);
      chk("R1 reset upd_valid", "reset", upd_valid, 0);
      chk("R1 reset intr_stat", "reset", intr_stat, 0);
      chk("R1 reset miss_cnt", "reset", miss_cnt, 0);
      apply(0, 1, 100, 3'b111, 0, "R1 frame before init");
      reinit(32'h1000, 5, 0, "R2 init narrow");
      chk("R3 narrow next", "R3", desc_addr[ADDR_W +: ADDR_W], 32'h1008);
      apply(0, 1, 100, 3'b001, 0, "R6 single");
      apply(0, 1, 0, 3'b111, 0, "R11 zero length");
      apply(0, 1, 200, 3'b110, 0, "R9 miss");
      apply(0, 1, 4096, 3'b111, 0, "R5 exact fit bcnt0");
      apply(0, 1, 4097, 3'b111, 0, "R5 spill into next");
      apply(0, 1, 9000, 3'b111, {3{12'd2048}}, "R7 overflow three");
      apply(0, 1, 9000, 3'b011, 0, "R6 stop at unowned");
      apply(0, 1, 12288, 3'b111, 0, "R5 three full buffers");
      ring_len = 9;
      apply(1, 1, 50, 3'b111, 0, "R2 init beats frame");
      reinit(32'h8000_0000, 1, 1, "R4 one entry wide");
      apply(0, 1, 5000, 3'b111, 0, "R4 wrap one entry");
      apply(0, 0, 0, 0, 0, "R12 idle");
      for (int v = 0; v < 400; v++) begin
         if ($urandom % 20 == 0)
            reinit($urandom & 32'hFFFF_FFF0, CNT_W'(1 + $urandom % 20), $urandom % 2, "R2 random init");
         else
            apply(0, ($urandom % 8) != 0, LEN_W'(($urandom % 16 == 0) ? 0 : 1 + $urandom % 12290),
                  {($urandom % 5) != 0, ($urandom % 5) != 0, ($urandom % 6) != 0},
                  {rnd_bcnt(), rnd_bcnt(), rnd_bcnt()}, "random");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog [R12] actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule